// File: doc/BRIEF.md
# Memory-Mapped Slave Error Reporter

This block sits next to a memory-mapped slave that forwards local bursts to a remote target as read and write requests. Every request is examined when it is accepted. The checks cover the burst count, the byte enables, and whether the whole burst lies inside the configured address window. A read that fails any of these checks is never sent onward. The block answers it locally with error beats. A read that passes is completed beat by beat from the remote responses. An error status on a response raises the error flag on that beat only. A timeout strobe makes every beat still owed come back flagged. The burst always ends with its full beat count.

Six sticky cause bits record the attribute faults. They are read and cleared through a small register port. A companion enable register masks the cause bits onto a single interrupt line.

The sequencing is done by a three-state machine.

States:
- `ST_IDLE`: no read is open.
- `ST_LIVE`: one beat is returned for each response.
- `ST_FLUSH`: one error beat is returned per clock until the beat count is used up.

Transitions:
- IDLE→LIVE on a clean read.
- IDLE→FLUSH on a faulty read.
- LIVE→FLUSH on a timeout.
- LIVE→IDLE when the last response arrives.
- FLUSH→IDLE when the last error beat is emitted.

Writes are accepted in one cycle from `ST_IDLE` and produce no beats.

Top module: `mmerr_reporter`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, `irq` is 0, and both registers read 0.
- R2: A response with `rsp_error`=1 produces one beat with `rd_err`=1 and `rd_data`=0. Later responses of the same burst are still returned.
- R3: A timeout during a live read turns every beat not yet returned into an error beat (`rd_err`=1, data 0), emitted one per cycle. A timeout in the same cycle as a response takes priority, and that response is dropped.
- R4: A read whose span `addr`..`addr`+beats-1 is not fully inside [`win_base`, `win_base`+`win_size`), or any read while `win_en`=0, is answered with error beats only and sets cause bit 5.
- R5: Every accepted read returns exactly its beat count. The beat count is the burst count, or 1 when the burst count is invalid. `req_ready` stays 0 from acceptance until the last beat, and no beat follows the last one.
- R6: A read burst count of 0 or above `MAX_BURST` (16) sets cause bit 0 and is answered with one error beat.
- R7: A read byte enable other than all ones sets cause bit 1. The whole read is answered with error beats.
- R8: For writes, an all-zero byte enable sets cause bit 2. An invalid burst count sets bit 3. An out-of-window span sets bit 4. Writes never produce read beats.
- R9: Cause bits are sticky. Writing the status register (`reg_sel`=0) with a 1 in a bit position clears that bit. Writing a 0 leaves the bit unchanged.
- R10: The enable register (`reg_sel`=1) is read/write. `irq` is 1 exactly when some cause bit and its enable bit are both 1.
- R11: A clean read passes each response's data through unchanged with `rd_err`=0, in arrival order.
- R12: Responses or timeouts that arrive while no read is open produce no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of first beat |
| req_burst | input | BCW | Burst count in beats |
| req_byteen | input | DW/8 | Byte enables |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| win_en | input | 1 | Address window enable |
| win_base | input | AW | Window base word address |
| win_size | input | AW | Window size in words |
| rsp_valid | input | 1 | Remote read response beat |
| rsp_error | input | 1 | Response carries error status |
| rsp_timeout | input | 1 | Outstanding read timed out |
| rsp_data | input | DW | Response data |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | DW | Read beat data (0 on error beats) |
| rd_err | output | 1 | Per-beat read error flag |
| reg_sel | input | 1 | 0 = cause status, 1 = enable |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data for `reg_sel` |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong beat counter would show up within one burst. The host would see a short burst, where `req_ready` returns early, or a long one, where an extra `rd_valid` appears after the last beat. A stuck or mis-steered state shows the same way a cycle after it goes wrong. Examples are a flush that waits for responses, or a live read that keeps passing data after a timeout. A lost or wrongly indexed cause bit appears at `reg_rdata` on the first read after the faulty request. It also appears on `irq` in the same cycle the bit is enabled.

// File: rtl/mmerr_pkg.sv
package mmerr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LIVE  = 2'd1,
        ST_FLUSH = 2'd2
    } beat_state_e;

    localparam int CAUSE_W     = 6;
    localparam int CZ_RD_BURST = 0;
    localparam int CZ_RD_BE    = 1;
    localparam int CZ_WR_BE    = 2;
    localparam int CZ_WR_BURST = 3;
    localparam int CZ_WR_OOB   = 4;
    localparam int CZ_RD_OOB   = 5;

endpackage

// File: rtl/mmerr_req_check.sv
module mmerr_req_check
    import mmerr_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BCW       = 8,
    parameter int BEW       = 4,
    parameter int MAX_BURST = 16
) (
    input  logic               is_write,
    input  logic [AW-1:0]      addr,
    input  logic [BCW-1:0]     burst,
    input  logic [BEW-1:0]     byteen,
    input  logic               win_en,
    input  logic [AW-1:0]      win_base,
    input  logic [AW-1:0]      win_size,
    output logic [CAUSE_W-1:0] causes,
    output logic [BCW-1:0]     beats,
    output logic               rd_fault
);
    localparam int SW = ((AW > BCW) ? AW : BCW) + 2;
    localparam logic [BCW-1:0] MAXB = BCW'(MAX_BURST);
    localparam logic [BCW-1:0] ONE  = BCW'(1);

    logic          burst_ok;
    logic          rd_be_ok;
    logic          wr_be_ok;
    logic          in_win;
    logic [SW-1:0] addr_x, base_x, size_x, beats_x, span;

    always_comb begin
        burst_ok = (burst != '0) && (burst <= MAXB);
        rd_be_ok = &byteen;
        wr_be_ok = |byteen;
        beats    = burst_ok ? burst : ONE;
    end

    always_comb begin
        addr_x  = SW'(addr);
        base_x  = SW'(win_base);
        size_x  = SW'(win_size);
        beats_x = SW'(beats);
        span    = addr_x - base_x + beats_x;
        in_win  = win_en && (addr_x >= base_x) && (span <= size_x);
    end

    always_comb begin
        causes              = '0;
        causes[CZ_RD_BURST] = !is_write && !burst_ok;
        causes[CZ_RD_BE]    = !is_write && !rd_be_ok;
        causes[CZ_WR_BE]    =  is_write && !wr_be_ok;
        causes[CZ_WR_BURST] =  is_write && !burst_ok;
        causes[CZ_WR_OOB]   =  is_write && !in_win;
        causes[CZ_RD_OOB]   = !is_write && !in_win;
        rd_fault = causes[CZ_RD_BURST] | causes[CZ_RD_BE] | causes[CZ_RD_OOB];
    end

endmodule

// File: rtl/mmerr_beat_fsm.sv
module mmerr_beat_fsm
    import mmerr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_rd,
    input  logic           start_fault,
    input  logic [BCW-1:0] start_beats,
    input  logic           rsp_valid,
    input  logic           rsp_error,
    input  logic           rsp_timeout,
    input  logic [DW-1:0]  rsp_data,
    output logic           idle,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic           rd_err
);
    localparam logic [BCW-1:0] ONE = BCW'(1);

    beat_state_e    state_q, state_d;
    logic [BCW-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rd) begin
                    state_d = start_fault ? ST_FLUSH : ST_LIVE;
                    left_d  = start_beats;
                end
            end
            ST_LIVE: begin
                if (rsp_timeout) begin
                    state_d = ST_FLUSH;
                end else if (rsp_valid) begin
                    left_d = left_q - ONE;
                    if (left_q == ONE) state_d = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                left_d = left_q - ONE;
                if (left_q == ONE) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                left_d  = '0;
            end
        endcase
    end

    // registered beat outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
            rd_data  <= '0;
            unique case (state_q)
                ST_LIVE: begin
                    if (!rsp_timeout && rsp_valid) begin
                        rd_valid <= 1'b1;
                        rd_err   <= rsp_error;
                        rd_data  <= rsp_error ? '0 : rsp_data;
                    end
                end
                ST_FLUSH: begin
                    rd_valid <= 1'b1;
                    rd_err   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign idle = (state_q == ST_IDLE);

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_err) |-> (rd_data == '0)); // R2
    AST_TIMEOUT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIVE && rsp_timeout) |=> (state_q == ST_FLUSH)); // R3
    AST_FLUSH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (rd_valid && rd_err)); // R3
    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (left_q != '0)); // R5
    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !rd_valid); // R12

endmodule

// File: rtl/mmerr_cause_regs.sv
module mmerr_cause_regs
    import mmerr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [CAUSE_W-1:0] reg_wdata,
    output logic [CAUSE_W-1:0] reg_rdata,
    output logic               irq
);
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] en_q;
    logic [CAUSE_W-1:0] clr_mask;
    logic [CAUSE_W-1:0] keep_mask;

    assign clr_mask  = (reg_we && !reg_sel) ? reg_wdata : '0;
    assign keep_mask = cause_q & ~clr_mask;

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cause_q[i] <= 1'b0;
            else if (set_vec[i])  cause_q[i] <= 1'b1;
            else if (clr_mask[i]) cause_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 en_q <= '0;
        else if (reg_we && reg_sel) en_q <= reg_wdata;
    end

    assign reg_rdata = reg_sel ? en_q : cause_q;
    assign irq       = |(cause_q & en_q);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(keep_mask)) == $past(keep_mask))); // R9
    AST_SET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq); // R10

endmodule

// File: rtl/mmerr_reporter.sv
module mmerr_reporter
    import mmerr_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int BCW       = 8,
    parameter int MAX_BURST = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [BCW-1:0]     req_burst,
    input  logic [DW/8-1:0]    req_byteen,
    output logic               req_ready,
    input  logic               win_en,
    input  logic [AW-1:0]      win_base,
    input  logic [AW-1:0]      win_size,
    input  logic               rsp_valid,
    input  logic               rsp_error,
    input  logic               rsp_timeout,
    input  logic [DW-1:0]      rsp_data,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    output logic               rd_err,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [CAUSE_W-1:0] reg_wdata,
    output logic [CAUSE_W-1:0] reg_rdata,
    output logic               irq
);
    localparam int BEW = DW / 8;

    logic [CAUSE_W-1:0] causes;
    logic [CAUSE_W-1:0] set_vec;
    logic [BCW-1:0]     beats;
    logic               rd_fault;
    logic               accept;
    logic               start_rd;
    logic               idle;

    mmerr_req_check #(
        .AW(AW), .BCW(BCW), .BEW(BEW), .MAX_BURST(MAX_BURST)
    ) u_check (
        .is_write (req_write),
        .addr     (req_addr),
        .burst    (req_burst),
        .byteen   (req_byteen),
        .win_en   (win_en),
        .win_base (win_base),
        .win_size (win_size),
        .causes   (causes),
        .beats    (beats),
        .rd_fault (rd_fault)
    );

    assign req_ready = idle;
    assign accept    = req_valid && idle;
    assign start_rd  = accept && !req_write;
    assign set_vec   = accept ? causes : '0;

    mmerr_beat_fsm #(.DW(DW), .BCW(BCW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_rd    (start_rd),
        .start_fault (rd_fault),
        .start_beats (beats),
        .rsp_valid   (rsp_valid),
        .rsp_error   (rsp_error),
        .rsp_timeout (rsp_timeout),
        .rsp_data    (rsp_data),
        .idle        (idle),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_err      (rd_err)
    );

    mmerr_cause_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    AST_WRITE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (req_ready && !rd_valid)); // R8
    AST_READ_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start_rd |=> !req_ready); // R5

endmodule

// File: tb/tb_mmerr_reporter.sv
module tb_mmerr_reporter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_burst = '0;
    logic [3:0]  req_byteen = '0;
    logic        req_ready;
    logic        win_en = 1'b1;
    logic [15:0] win_base = 16'h1000, win_size = 16'h0100;
    logic        rsp_valid = 0, rsp_error = 0, rsp_timeout = 0;
    logic [31:0] rsp_data = '0;
    logic        rd_valid, rd_err;
    logic [31:0] rd_data;
    logic        reg_sel = 0, reg_we = 0;
    logic [5:0]  reg_wdata = '0;
    logic [5:0]  reg_rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mmerr_reporter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_burst(req_burst), .req_byteen(req_byteen),
        .req_ready(req_ready), .win_en(win_en), .win_base(win_base), .win_size(win_size),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_timeout(rsp_timeout),
        .rsp_data(rsp_data), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  burst;
        logic [3:0]  be;
        logic [5:0]  cause;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1000, 8'd4,  4'hF, 6'h00},
        '{1'b0, 16'h10FC, 8'd4,  4'hF, 6'h00},
        '{1'b0, 16'h10FD, 8'd4,  4'hF, 6'h20},
        '{1'b0, 16'h1010, 8'd0,  4'hF, 6'h01},
        '{1'b0, 16'h1010, 8'd17, 4'hF, 6'h01},
        '{1'b0, 16'h1010, 8'd2,  4'h7, 6'h02},
        '{1'b1, 16'h1020, 8'd3,  4'h0, 6'h04},
        '{1'b1, 16'h1020, 8'd0,  4'hF, 6'h08},
        '{1'b1, 16'h0FFF, 8'd1,  4'hF, 6'h10},
        '{1'b1, 16'h1020, 8'd16, 4'h1, 6'h00},
        '{1'b0, 16'h0F00, 8'd2,  4'h3, 6'h22}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [5:0] d);
        @(negedge clk); reg_sel = sel; reg_we = 1; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_wdata = '0;
    endtask

    task automatic reg_check(input logic sel, input logic [5:0] exp, input string req);
        reg_sel = sel; #0;
        @(negedge clk);
        check(reg_rdata == exp, req, {26'd0, reg_rdata}, {26'd0, exp});
    endtask

    function automatic int exp_beats(input logic [7:0] b);
        return (b == 0 || b > 16) ? 1 : int'(b);
    endfunction

    task automatic do_read(input logic [15:0] a, input logic [7:0] b, input logic [3:0] be,
                           input int err_beat, input int to_beat, input bit all_err, input string req);
        int nb = exp_beats(b);
        int got = 0, sent = 0, guard = 0;
        bit timed = 0;
        bit exp_err;
        logic [31:0] exp_d;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_burst = b; req_byteen = be;
        @(negedge clk);
        req_valid = 0;
        check(req_ready == 1'b0, "R5 ready low after read accept", {31'd0, req_ready}, 32'd0);
        while (got < nb && guard < 100) begin
            guard++;
            rsp_valid = 0; rsp_error = 0; rsp_timeout = 0;
            if (!all_err && !timed && sent < nb) begin
                if (sent == to_beat) begin
                    rsp_timeout = 1; timed = 1;
                end else begin
                    rsp_valid = 1; rsp_error = (sent == err_beat);
                    rsp_data = 32'hA500_0000 + sent; sent++;
                end
            end
            @(negedge clk);
            if (rd_valid) begin
                exp_err = all_err || (got == err_beat) || (to_beat >= 0 && got >= to_beat);
                exp_d = exp_err ? 32'd0 : 32'hA500_0000 + got;
                check(rd_err == exp_err, req, {31'd0, rd_err}, {31'd0, exp_err});
                check(rd_data == exp_d, req, rd_data, exp_d);
                got++;
            end
        end
        rsp_valid = 0; rsp_error = 0; rsp_timeout = 0;
        check(got == nb, "R5 beat count", got, nb);
        check(req_ready == 1'b1, "R5 ready after last beat", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        check(rd_valid == 1'b0, "R5 no extra beat", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] b, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_burst = b; req_byteen = be;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check(rd_valid == 1'b0 && req_ready == 1'b1, "R8 write gives no beat",
              {30'd0, rd_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(req_ready == 1 && rd_valid == 0 && irq == 0, "R1 reset outputs",
              {29'd0, req_ready, rd_valid, irq}, 32'h4);
        rst_n = 1;
        reg_check(1'b0, 6'h00, "R1 status after reset");
        reg_check(1'b1, 6'h00, "R1 enable after reset");

        // table: R4 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            reg_write(1'b0, 6'h3F);
            if (VECS[i].wr)
                do_write(VECS[i].addr, VECS[i].burst, VECS[i].be);
            else
                do_read(VECS[i].addr, VECS[i].burst, VECS[i].be, -1, -1,
                        VECS[i].cause != 6'h00, "R11/R4/R6/R7 table read");
            reg_check(1'b0, VECS[i].cause, "R8/R4/R6/R7 table cause");
        end

        // R9: W1C behaviour on last vector's causes (bits 1 and 5)
        reg_write(1'b0, 6'h00);
        reg_check(1'b0, 6'h22, "R9 zero write keeps");
        reg_write(1'b0, 6'h02);
        reg_check(1'b0, 6'h20, "R9 one clears bit");

        // R10: enable mask and interrupt
        reg_write(1'b1, 6'h01);
        reg_check(1'b1, 6'h01, "R10 enable readback");
        check(irq == 1'b0, "R10 irq masked", {31'd0, irq}, 32'd0);
        reg_write(1'b1, 6'h20);
        @(negedge clk);
        check(irq == 1'b1, "R10 irq enabled", {31'd0, irq}, 32'd1);
        reg_write(1'b0, 6'h20);
        check(irq == 1'b0, "R10 irq after clear", {31'd0, irq}, 32'd0);
        reg_write(1'b1, 6'h00);

        // R2: error status on beat 1 of 4, burst continues
        do_read(16'h1000, 8'd4, 4'hF, 1, -1, 1'b0, "R2 error status beat");
        // R3: timeout at beat 2 of 5
        do_read(16'h1040, 8'd5, 4'hF, -1, 2, 1'b0, "R3 timeout flush");
        // R3: timeout at first beat of 3
        do_read(16'h1040, 8'd3, 4'hF, -1, 0, 1'b0, "R3 timeout at start");
        // R11: maximum clean burst
        do_read(16'h10F0, 8'd16, 4'hF, -1, -1, 1'b0, "R11 max clean burst");

        // R4: window disabled
        reg_write(1'b0, 6'h3F);
        win_en = 0;
        do_read(16'h1000, 8'd3, 4'hF, -1, -1, 1'b1, "R4 window disabled");
        reg_check(1'b0, 6'h20, "R4 disabled window cause");
        win_en = 1;

        // R12: stray responses while idle
        @(negedge clk); rsp_valid = 1; rsp_data = 32'hDEAD_BEEF;
        @(negedge clk); rsp_valid = 0; rsp_timeout = 1;
        check(rd_valid == 1'b0, "R12 stray response", {31'd0, rd_valid}, 32'd0);
        @(negedge clk); rsp_timeout = 0;
        check(rd_valid == 1'b0 && req_ready == 1'b1, "R12 stray timeout",
              {30'd0, rd_valid, req_ready}, 32'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule